// File: doc/BRIEF.md
# Two-Level Extended Opcode Dispatcher with Mode-Dependent Traps

This block sits between the instruction fetch stage and the microcode sequencer of a stack machine. It classifies each 8-bit extended opcode in two steps. The upper four bits pick one of sixteen groups, and a per-group enable says whether that group exists at all. If the group exists, a per-opcode enable then says whether the individual entry exists. An opcode that passes both steps produces a dispatch target, given as a group index plus an entry index. In the same cycle the block copies the top-of-stack word into a scratch register and advances the stack pointer, ready for a push.

Any opcode that fails either step raises a trap instead, and the stack pointer stays where it was. When a whole group is missing, the second-level lookup is abandoned and the trap points at one shared entry, the all-ones opcode. The trap flavour depends on three things: the execution mode, whether a software opcode-trap table has been installed, and whether the opcode belongs to the floating-point group. In legacy mode a floating-point miss also latches the offending opcode into a dedicated register.

Both enable sets are held in configuration registers. They leave reset holding the standard opcode set and can be reloaded in a single cycle.

Top module: `opdisp_unit`

## Requirements
- R1: A dispatch reports `dispatch_group` = opcode[7:4] and `dispatch_entry` = opcode[3:0] of the accepted opcode.
- R2: After reset the group-enable register equals 16'h045B, so groups 0, 1, 3, 4, 6 and 10 are present and every other group is absent.
- R3: An opcode in an absent group traps with `trap_entry` = 8'hFF, whatever its opcode-enable bit holds.
- R4: After reset the opcode-enable register is all ones except bits 2, 4, 12, 13, 65, 67, 69 to 79 and 164. An opcode whose group is present and whose bit is clear traps with `trap_entry` equal to the opcode.
- R5: On a dispatch, `temp_q` takes the `tos` value presented with the opcode, and `stack_ptr` increases by one modulo 2^SP_W. Both are visible in the cycle `dispatch_valid` is high.
- R6: On a trap, `stack_ptr` and `temp_q` keep their previous values.
- R7: With `alt_mode`=0 and an opcode outside group 1, a trap reports kind 0 and `trap_code` 8'h3C.
- R8: With `alt_mode`=0 and an opcode in group 1 (the floating-point group), a trap reports kind 1 and `trap_code` 8'h5F, and `trap_opcode` takes the opcode. Every other trap and every dispatch leaves `trap_opcode` unchanged.
- R9: With `alt_mode`=1, a trap reports kind 2 if `optab_present` is 1 and kind 3 if it is 0, with `trap_code` 8'h3C, for any group.
- R10: For each cycle with `op_valid` high, exactly one of `dispatch_valid` and `trap_valid` is high for one cycle in the following cycle. Neither is high at any other time.
- R11: `cfg_wr` loads both enable registers at the clock edge. An opcode accepted in the same cycle is classified with the enables held before that load.
- R12: While `rst_n` is low at a clock edge, all outputs, `stack_ptr`, `temp_q` and `trap_opcode` become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Opcode strobe, one opcode per high cycle |
| opcode | input | 8 | Extended opcode |
| tos | input | DATA_W | Top-of-stack value presented with the opcode |
| alt_mode | input | 1 | 0 = legacy trap scheme, 1 = alternate scheme |
| optab_present | input | 1 | Software opcode-trap table installed (alternate mode) |
| cfg_wr | input | 1 | Load both enable registers |
| cfg_grp_mask | input | 16 | New group enables, bit g for group g |
| cfg_op_mask | input | 256 | New opcode enables, bit n for opcode n |
| dispatch_valid | output | 1 | Dispatch pulse |
| dispatch_group | output | 4 | Group index of the dispatch target |
| dispatch_entry | output | 4 | Entry index within the group |
| trap_valid | output | 1 | Trap pulse |
| trap_kind | output | 2 | 0 legacy generic, 1 legacy floating point, 2 table trap, 3 trap-zero |
| trap_code | output | 8 | Trap code for the handler |
| trap_entry | output | 8 | Opcode, or 8'hFF for an absent group |
| trap_opcode | output | 8 | Opcode latched by the last floating-point trap |
| stack_ptr | output | SP_W | Stack pointer |
| temp_q | output | DATA_W | Scratch copy of top of stack |

## Verification
Two functions can land in the same cycle: a configuration load and the classification of an opcode. The bench raises `cfg_wr` in the very cycle it presents an opcode whose outcome the new enables would flip. The new enables turn group 2 on and group 1 off. The expected trap or dispatch is computed from the enables as they stood before the load, and the opcodes that follow are then judged against the new enables. The same collision is repeated when the defaults are restored, with an opcode that dispatches under the outgoing set and traps under the incoming one.

// File: rtl/opdisp_pkg.sv
// Package opdisp_pkg
// Shared constants, trap kind encoding and reset values for the two-level
// opcode dispatcher. Assumes an 8-bit opcode split as 4 group bits over
// 4 entry bits; the reset masks are computed, not tabulated.
package opdisp_pkg;

    localparam int OP_W   = 8;
    localparam int GRP_W  = 4;
    localparam int ENT_W  = OP_W - GRP_W;
    localparam int N_GRP  = 1 << GRP_W;
    localparam int N_ENT  = 1 << ENT_W;
    localparam int N_OP   = 1 << OP_W;

    localparam logic [GRP_W-1:0] FP_GROUP     = GRP_W'(1);
    localparam logic [OP_W-1:0]  SHARED_ENTRY = '1;

    localparam logic [7:0] CODE_UNIMPL = 8'h3C;
    localparam logic [7:0] CODE_FP     = 8'h5F;

    typedef enum logic [1:0] {
        TK_LEGACY_GENERIC = 2'd0,
        TK_LEGACY_FP      = 2'd1,
        TK_ALT_TABLE      = 2'd2,
        TK_ALT_ZERO       = 2'd3
    } trap_kind_t;

    // Reset value of the group enables: groups 0,1,3,4,6,10.
    function automatic logic [N_GRP-1:0] default_group_mask();
        logic [N_GRP-1:0] m;
        m = '0;
        m[0]  = 1'b1;
        m[1]  = 1'b1;
        m[3]  = 1'b1;
        m[4]  = 1'b1;
        m[6]  = 1'b1;
        m[10] = 1'b1;
        return m;
    endfunction

    // Reset value of the opcode enables: all present except a few holes.
    function automatic logic [N_OP-1:0] default_op_mask();
        logic [N_OP-1:0] m;
        m = '1;
        m[8'o002] = 1'b0;
        m[8'o004] = 1'b0;
        m[8'o014] = 1'b0;
        m[8'o015] = 1'b0;
        m[8'o244] = 1'b0;
        m[8'o101] = 1'b0;
        m[8'o103] = 1'b0;
        for (int k = 8'o105; k <= 8'o117; k++) begin
            m[k] = 1'b0;
        end
        return m;
    endfunction

endpackage

// File: rtl/opdisp_cfg_regs.sv
// Module opdisp_cfg_regs
// Holds the group-enable and opcode-enable registers. Both load together
// on wr; reset restores the standard opcode set from the package.
module opdisp_cfg_regs
    import opdisp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [N_GRP-1:0] grp_in,
    input  logic [N_OP-1:0]  op_in,
    output logic [N_GRP-1:0] grp_q,
    output logic [N_OP-1:0]  op_q
);

    // Configuration storage with default reload on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q <= default_group_mask();
            op_q  <= default_op_mask();
        end else if (wr) begin
            grp_q <= grp_in;
            op_q  <= op_in;
        end
    end

endmodule

// File: rtl/opdisp_decode.sv
// Module opdisp_decode
// Combinational two-level classifier. Level one tests the group enable;
// level two tests the opcode enable within that group's slice. A missing
// group cancels level two and redirects to the shared trap entry.
module opdisp_decode
    import opdisp_pkg::*;
(
    input  logic [OP_W-1:0]  opcode,
    input  logic [N_GRP-1:0] grp_mask,
    input  logic [N_OP-1:0]  op_mask,
    output logic             implemented,
    output logic             is_fp,
    output logic [GRP_W-1:0] grp_idx,
    output logic [ENT_W-1:0] ent_idx,
    output logic [OP_W-1:0]  trap_entry
);

    logic [N_GRP-1:0] grp_sel;
    logic [N_GRP-1:0] slice_hit;
    logic             grp_hit;
    logic             ent_hit;

    assign grp_idx = opcode[OP_W-1:ENT_W];
    assign ent_idx = opcode[ENT_W-1:0];

    // Per-group one-hot select and the selected entry bit of each slice.
    for (genvar g = 0; g < N_GRP; g++) begin : g_group
        logic [N_ENT-1:0] slice;
        assign slice        = op_mask[g*N_ENT +: N_ENT];
        assign grp_sel[g]   = (grp_idx == GRP_W'(g));
        assign slice_hit[g] = slice[ent_idx];
    end

    // First level, then second level gated by the group.
    always_comb begin
        grp_hit     = |(grp_sel & grp_mask);
        ent_hit     = |(grp_sel & slice_hit);
        implemented = grp_hit & ent_hit;
        is_fp       = (grp_idx == FP_GROUP);
        trap_entry  = grp_hit ? opcode : SHARED_ENTRY;
    end

endmodule

// File: rtl/opdisp_trap_sel.sv
// Module opdisp_trap_sel
// Chooses the trap flavour and code from mode, table presence and the
// floating-point group flag. Pure combinational.
module opdisp_trap_sel
    import opdisp_pkg::*;
(
    input  logic       alt_mode,
    input  logic       table_present,
    input  logic       is_fp,
    output trap_kind_t kind,
    output logic [7:0] code
);

    // Mode-dependent trap selection.
    always_comb begin
        if (alt_mode) begin
            kind = table_present ? TK_ALT_TABLE : TK_ALT_ZERO;
            code = CODE_UNIMPL;
        end else if (is_fp) begin
            kind = TK_LEGACY_FP;
            code = CODE_FP;
        end else begin
            kind = TK_LEGACY_GENERIC;
            code = CODE_UNIMPL;
        end
    end

endmodule

// File: rtl/opdisp_unit.sv
// Module opdisp_unit
// Top of the two-level opcode dispatcher. Registers a dispatch or a trap
// one cycle after op_valid, advances the stack pointer and captures the
// top of stack only on dispatch, and latches the opcode on legacy
// floating-point traps. Assumes one opcode per op_valid cycle.
module opdisp_unit
    import opdisp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] tos,
    input  logic              alt_mode,
    input  logic              optab_present,
    input  logic              cfg_wr,
    input  logic [15:0]       cfg_grp_mask,
    input  logic [255:0]      cfg_op_mask,
    output logic              dispatch_valid,
    output logic [3:0]        dispatch_group,
    output logic [3:0]        dispatch_entry,
    output logic              trap_valid,
    output logic [1:0]        trap_kind,
    output logic [7:0]        trap_code,
    output logic [7:0]        trap_entry,
    output logic [7:0]        trap_opcode,
    output logic [SP_W-1:0]   stack_ptr,
    output logic [DATA_W-1:0] temp_q
);

    logic [N_GRP-1:0] grp_mask;
    logic [N_OP-1:0]  op_mask;
    logic             impl;
    logic             fp;
    logic [GRP_W-1:0] d_grp;
    logic [ENT_W-1:0] d_ent;
    logic [OP_W-1:0]  d_entry;
    trap_kind_t       t_kind;
    logic [7:0]       t_code;
    logic             take_disp;
    logic             take_trap;

    opdisp_cfg_regs u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .grp_in (cfg_grp_mask),
        .op_in  (cfg_op_mask),
        .grp_q  (grp_mask),
        .op_q   (op_mask)
    );

    opdisp_decode u_dec (
        .opcode      (opcode),
        .grp_mask    (grp_mask),
        .op_mask     (op_mask),
        .implemented (impl),
        .is_fp       (fp),
        .grp_idx     (d_grp),
        .ent_idx     (d_ent),
        .trap_entry  (d_entry)
    );

    opdisp_trap_sel u_tsel (
        .alt_mode      (alt_mode),
        .table_present (optab_present),
        .is_fp         (fp),
        .kind          (t_kind),
        .code          (t_code)
    );

    // Accept qualifiers for the two outcomes.
    always_comb begin
        take_disp = op_valid & impl;
        take_trap = op_valid & ~impl;
    end

    // Output pulses and dispatch target register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dispatch_valid <= 1'b0;
            trap_valid     <= 1'b0;
            dispatch_group <= '0;
            dispatch_entry <= '0;
        end else begin
            dispatch_valid <= take_disp;
            trap_valid     <= take_trap;
            if (take_disp) begin
                dispatch_group <= d_grp;
                dispatch_entry <= d_ent;
            end
        end
    end

    // Trap descriptor register and floating-point opcode latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_kind   <= '0;
            trap_code   <= '0;
            trap_entry  <= '0;
            trap_opcode <= '0;
        end else if (take_trap) begin
            trap_kind  <= t_kind;
            trap_code  <= t_code;
            trap_entry <= d_entry;
            if (t_kind == TK_LEGACY_FP) begin
                trap_opcode <= opcode;
            end
        end
    end

    // Stack pointer pre-increment and top-of-stack capture on dispatch only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stack_ptr <= '0;
            temp_q    <= '0;
        end else if (take_disp) begin
            stack_ptr <= stack_ptr + SP_W'(1);
            temp_q    <= tos;
        end
    end

endmodule

// File: rtl/opdisp_unit_chk.sv
// Module opdisp_unit_chk
// Property checker bound to opdisp_unit; observes ports only.
module opdisp_unit_chk #(
    parameter int DATA_W = 16,
    parameter int SP_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [7:0]        opcode,
    input logic [DATA_W-1:0] tos,
    input logic              alt_mode,
    input logic              dispatch_valid,
    input logic [3:0]        dispatch_group,
    input logic [3:0]        dispatch_entry,
    input logic              trap_valid,
    input logic [1:0]        trap_kind,
    input logic [7:0]        trap_code,
    input logic [7:0]        trap_opcode,
    input logic [SP_W-1:0]   stack_ptr,
    input logic [DATA_W-1:0] temp_q
);

    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dispatch_valid, trap_valid}));

    assert_answer_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (dispatch_valid || trap_valid));

    assert_no_orphan_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dispatch_valid || trap_valid) |-> $past(op_valid));

    assert_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_valid |-> ({dispatch_group, dispatch_entry} == $past(opcode)));

    assert_push_prep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_valid |-> (stack_ptr == SP_W'($past(stack_ptr) + 1'b1)
                            && temp_q == $past(tos)));

    assert_trap_keeps_stack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> ($stable(stack_ptr) && $stable(temp_q)));

    assert_fp_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_kind == 2'd1) |-> (trap_code == 8'h5F
                                               && trap_opcode == $past(opcode)));

    assert_mode_family_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (trap_kind[1] == $past(alt_mode)));

endmodule

bind opdisp_unit opdisp_unit_chk #(.DATA_W(DATA_W), .SP_W(SP_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_valid       (op_valid),
    .opcode         (opcode),
    .tos            (tos),
    .alt_mode       (alt_mode),
    .dispatch_valid (dispatch_valid),
    .dispatch_group (dispatch_group),
    .dispatch_entry (dispatch_entry),
    .trap_valid     (trap_valid),
    .trap_kind      (trap_kind),
    .trap_code      (trap_code),
    .trap_opcode    (trap_opcode),
    .stack_ptr      (stack_ptr),
    .temp_q         (temp_q)
);

// File: tb/opdisp_unit_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts each outcome and queues it, the
// monitor compares the design's pulses against the queue.
module opdisp_unit_bench;

    localparam int DATA_W = 16;
    localparam int SP_W   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [7:0]        opcode = '0;
    logic [DATA_W-1:0] tos = '0;
    logic              alt_mode = 1'b0;
    logic              optab_present = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [15:0]       cfg_grp_mask = '0;
    logic [255:0]      cfg_op_mask = '0;
    logic              dispatch_valid;
    logic [3:0]        dispatch_group;
    logic [3:0]        dispatch_entry;
    logic              trap_valid;
    logic [1:0]        trap_kind;
    logic [7:0]        trap_code;
    logic [7:0]        trap_entry;
    logic [7:0]        trap_opcode;
    logic [SP_W-1:0]   stack_ptr;
    logic [DATA_W-1:0] temp_q;

    always #2.5 clk = ~clk;

    opdisp_unit #(.DATA_W(DATA_W), .SP_W(SP_W)) u_opdisp_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .tos(tos),
        .alt_mode(alt_mode), .optab_present(optab_present), .cfg_wr(cfg_wr),
        .cfg_grp_mask(cfg_grp_mask), .cfg_op_mask(cfg_op_mask),
        .dispatch_valid(dispatch_valid), .dispatch_group(dispatch_group),
        .dispatch_entry(dispatch_entry), .trap_valid(trap_valid), .trap_kind(trap_kind),
        .trap_code(trap_code), .trap_entry(trap_entry), .trap_opcode(trap_opcode),
        .stack_ptr(stack_ptr), .temp_q(temp_q)
    );

    typedef struct {
        bit              disp;
        bit              alt;
        bit              gmiss;
        logic [3:0]      grp;
        logic [3:0]      ent;
        logic [1:0]      kind;
        logic [7:0]      code;
        logic [7:0]      entry;
        logic [7:0]      topc;
        logic [SP_W-1:0] sp;
        logic [15:0]     temp;
    } exp_t;

    exp_t        sb[$];
    int          n_run = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    bit          mon_on = 1'b0;
    logic [15:0]  m_grp;
    logic [255:0] m_op;
    logic [SP_W-1:0] m_sp = '0;
    logic [15:0]  m_temp = '0;
    logic [7:0]   m_topc = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Present one opcode (optionally with a configuration load) and queue the prediction.
    task automatic send(input logic [7:0] op, input bit alt, input bit tab,
                        input logic [15:0] data, input bit wr,
                        input logic [15:0] ng, input logic [255:0] no);
        exp_t e;
        @(negedge clk);
        op_valid = 1'b1; opcode = op; alt_mode = alt; optab_present = tab; tos = data;
        cfg_wr = wr; cfg_grp_mask = ng; cfg_op_mask = no;
        e = '{default: '0};
        e.alt   = alt;
        e.gmiss = !m_grp[op[7:4]];
        e.grp   = op[7:4];
        e.ent   = op[3:0];
        if (m_grp[op[7:4]] && m_op[op]) begin
            e.disp = 1'b1;
            m_sp   = m_sp + 1'b1;
            m_temp = data;
        end else begin
            e.entry = e.gmiss ? 8'hFF : op;
            if (alt) begin
                e.kind = tab ? 2'd2 : 2'd3;
                e.code = 8'h3C;
            end else if (op[7:4] == 4'd1) begin
                e.kind = 2'd1;
                e.code = 8'h5F;
                m_topc = op;
            end else begin
                e.kind = 2'd0;
                e.code = 8'h3C;
            end
        end
        e.sp = m_sp; e.temp = m_temp; e.topc = m_topc;
        sb.push_back(e);
        if (wr) begin
            m_grp = ng;
            m_op  = no;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 1'b0; cfg_wr = 1'b0;
        end
    endtask

    // Monitor: compare each pulse with the oldest prediction.
    always @(negedge clk) begin
        if (mon_on) begin
            if (dispatch_valid || trap_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R10", "unexpected pulse", {dispatch_valid, trap_valid}, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(dispatch_valid == e.disp && trap_valid == !e.disp, "R10",
                        "outcome", {dispatch_valid, trap_valid}, {e.disp, !e.disp});
                    if (e.disp) begin
                        chk({dispatch_group, dispatch_entry} == {e.grp, e.ent}, "R1",
                            "target", {dispatch_group, dispatch_entry}, {e.grp, e.ent});
                        chk(stack_ptr == e.sp, "R5", "stack_ptr", stack_ptr, e.sp);
                        chk(temp_q == e.temp, "R5", "temp_q", temp_q, e.temp);
                    end else begin
                        chk(trap_entry == e.entry, e.gmiss ? "R3" : "R4", "trap_entry",
                            trap_entry, e.entry);
                        chk(trap_kind == e.kind, e.alt ? "R9" : (e.kind == 2'd1 ? "R8" : "R7"),
                            "trap_kind", trap_kind, e.kind);
                        chk(trap_code == e.code, e.alt ? "R9" : (e.kind == 2'd1 ? "R8" : "R7"),
                            "trap_code", trap_code, e.code);
                        chk(stack_ptr == e.sp, "R6", "stack_ptr", stack_ptr, e.sp);
                        chk(temp_q == e.temp, "R6", "temp_q", temp_q, e.temp);
                    end
                    chk(trap_opcode == e.topc, "R8", "trap_opcode", trap_opcode, e.topc);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        logic [15:0]  g2;
        logic [255:0] o2;
        logic [255:0] dflt;
        m_grp = 16'h045B;
        m_op  = '1;
        foreach (m_op[k]) begin
            if (k == 2 || k == 4 || k == 12 || k == 13 || k == 65 || k == 67 ||
                (k >= 69 && k <= 79) || k == 164) m_op[k] = 1'b0;
        end
        dflt = m_op;

        // R12: reset state.
        repeat (3) @(negedge clk);
        chk(dispatch_valid == 0 && trap_valid == 0, "R12", "pulses", {dispatch_valid, trap_valid}, 0);
        chk(stack_ptr == 0, "R12", "stack_ptr", stack_ptr, 0);
        chk(temp_q == 0, "R12", "temp_q", temp_q, 0);
        chk(trap_opcode == 0, "R12", "trap_opcode", trap_opcode, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R2 R4 R7 R8: every opcode, legacy mode, default enables.
        for (int i = 0; i < 256; i++) send(8'(i), 1'b0, 1'b0, 16'hA5A5 ^ 16'(i * 16'h1357), 1'b0, '0, '0);
        idle(2);
        // R9: alternate mode with table, then without.
        for (int i = 0; i < 256; i++) send(8'(i), 1'b1, 1'b1, 16'h3C3C + 16'(i), 1'b0, '0, '0);
        for (int i = 255; i >= 0; i--) send(8'(i), 1'b1, 1'b0, 16'(i * 16'h0101), 1'b0, '0, '0);
        idle(3);
        chk(sb.size() == 0, "R10", "queue drained", sb.size(), 0);

        // R11: load collides with an opcode; group 2 on, group 1 off, opcode 0x21 off.
        g2 = (16'h045B | 16'h0004) & ~16'h0002;
        o2 = '1; o2[8'h21] = 1'b0;
        send(8'h20, 1'b0, 1'b0, 16'h1111, 1'b1, g2, o2);
        send(8'h20, 1'b0, 1'b0, 16'h2222, 1'b0, '0, '0);
        send(8'h21, 1'b0, 1'b0, 16'h3333, 1'b0, '0, '0);
        send(8'h15, 1'b0, 1'b0, 16'h4444, 1'b0, '0, '0);  // R3 with FP latch, R8
        send(8'h02, 1'b0, 1'b0, 16'h5555, 1'b0, '0, '0);
        idle(2);
        // R11: restore defaults while 0x02 is accepted under the outgoing set.
        send(8'h02, 1'b0, 1'b0, 16'h6666, 1'b1, 16'h045B, dflt);
        send(8'h02, 1'b0, 1'b0, 16'h7777, 1'b0, '0, '0);
        send(8'h20, 1'b1, 1'b1, 16'h8888, 1'b0, '0, '0);
        send(8'h18, 1'b0, 1'b0, 16'h9999, 1'b0, '0, '0);
        idle(4);
        chk(sb.size() == 0, "R10", "queue drained", sb.size(), 0);
        chk(dispatch_valid == 0 && trap_valid == 0, "R10", "idle pulses",
            {dispatch_valid, trap_valid}, 0);
        summary();
    end

endmodule